// File: doc/BRIEF.md
# Dual-Channel IDE Interrupt Status Register Block

This block holds the interrupt status of a two-channel IDE controller and drives its single level-sensitive interrupt line. Each channel's status bit can be read at two byte addresses of configuration space. One copy sits in a per-channel register, and the other sits in a shared register that also carries the two channel mask bits. Both copies are always equal, because the block stores one flop per channel and decodes every alias from it.

The drive side supplies one request level per channel. A rising level sets the channel's status, and a falling level clears it. Software clears a status bit by writing a one to it through either alias. Only one byte of configuration space is ordinary read/write storage: the channel enable byte. Bus-master writes can replace the two mask bits. They also update a per-channel bus-master status byte, whose error and interrupt flags clear when a one is written to them. A DMA engine outside this block raises those flags through set pulses.

Top module: `ide_irq_status_regs`

## Requirements
- R1: After reset, all status bits, mask bits and bus-master status bytes are zero and `irq` is low. The channel enable byte reads 0x0C, or 0x04 when the secondary channel is absent.
- R2: The channel 0 status bit reads at byte 0x50 bit 2 and at byte 0x71 bit 2. The channel 1 status bit reads at byte 0x57 bit 4 and at byte 0x71 bit 3. Both copies of a channel always read the same value. Reads use dword address `cfg_raddr` (byte address / 4), with byte n on `cfg_rdata[8n+7:8n]`.
- R3: A 0-to-1 change of `irq_req[c]` sets channel c's status bit, and a 1-to-0 change clears it. Either change is visible in both copies from the clock edge that samples the change.
- R4: A configuration write with a 1 in a status bit position, through either alias, clears that channel's status in both copies. A 0 in that position changes nothing.
- R5: All other bits of bytes 0x50, 0x57 and 0x71 ignore configuration writes. This includes the mask bits 5:4 of 0x71.
- R6: A configuration write acts on every byte lane whose `cfg_be` bit is set, and on no other lane. A single access can write the enable byte and clear a status bit at the same time.
- R7: Byte 0x51 is a fully writable channel enable byte. Bit 2 enables channel 0 and bit 3 enables channel 1.
- R8: A bus-master write to offset 1 (either channel) copies `bm_wdata[5:4]` into bits 5:4 of byte 0x71. Bit 4 is the channel 0 mask and bit 5 is the channel 1 mask. All other bits are left unchanged. Bus-master writes to offsets 0 and 3 leave the masks unchanged.
- R9: A bus-master write to offset 2 for channel c sets that channel's status byte to (data AND 0x60) OR (old bit 0) OR (old bits 2:1 AND NOT data bits 2:1). Pulses on `dma_set[3c+2:3c]` OR into bits 2:0. The status byte of the other channel is unaffected.
- R10: `irq` is high exactly when some channel has its status set and its mask clear. It follows register changes from the next clock edge on.
- R11: When a request rising change and a configuration clear of the same channel arrive in one cycle, the status ends up set.
- R12: Reads have no side effects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_waddr | input | 6 | Configuration write dword address |
| cfg_be | input | 4 | Configuration write byte enables |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_raddr | input | 6 | Configuration read dword address |
| cfg_rdata | output | 32 | Configuration read data (combinational) |
| bm_we | input | 1 | Bus-master register write strobe |
| bm_chan | input | 1 | Bus-master channel select |
| bm_off | input | 3 | Bus-master register offset |
| bm_wdata | input | 8 | Bus-master write data |
| bm_status | output | 16 | Bus-master status bytes, channel c in bits 8c+7:8c |
| dma_set | input | 6 | Set pulses for bus-master status bits 2:0, channel c in bits 3c+2:3c |
| irq_req | input | 2 | Per-channel interrupt request levels from the drives |
| irq | output | 1 | Level-sensitive interrupt output |

## Verification
The bench clears each channel through each of its two aliases. A design that kept separate copies without mirroring would leave the other alias set and the interrupt asserted. It writes zeros and all-ones-except-status patterns, which catch a design that treats the bytes as plain storage or clears on any write. Partial byte enables show whether lanes without an enable leak through. A simultaneous request edge and clear settles the priority between the two. Mask writes and bus-master status writes with mixed bit patterns expose a wrong field position or a status rule that drops bit 0 or clears on zero.

// File: rtl/ide_irq_pkg.sv
package ide_irq_pkg;
  localparam int NCH = 2;
  localparam int CH_W = 1;

  // dword addresses and byte lanes of the aliased registers
  localparam logic [5:0] DW_CH0 = 6'h14;  // byte 0x50
  localparam int         LN_CH0 = 0;
  localparam logic [5:0] DW_EN  = 6'h14;  // byte 0x51
  localparam int         LN_EN  = 1;
  localparam logic [5:0] DW_CH1 = 6'h15;  // byte 0x57
  localparam int         LN_CH1 = 3;
  localparam logic [5:0] DW_SHR = 6'h1C;  // byte 0x71
  localparam int         LN_SHR = 1;

  // bit positions inside those bytes
  localparam int B_CH0_STS = 2;
  localparam int B_CH1_STS = 4;
  localparam int B_SHR_S0  = 2;
  localparam int B_SHR_S1  = 3;
  localparam int B_SHR_M0  = 4;

  localparam logic [2:0] BM_OFF_CTL = 3'd1;
  localparam logic [2:0] BM_OFF_STS = 3'd2;

  function automatic logic [7:0] bm_status_next(input logic [7:0] old, input logic [7:0] val);
    return (val & 8'h60) | (old & 8'h01) | (old & ~val & 8'h06);
  endfunction

  function automatic logic irq_level(input logic [NCH-1:0] sts, input logic [NCH-1:0] msk);
    return |(sts & ~msk);
  endfunction

  function automatic logic [7:0] shared_byte(input logic [NCH-1:0] sts, input logic [NCH-1:0] msk);
    logic [7:0] b;
    b = '0;
    b[B_SHR_S0] = sts[0];
    b[B_SHR_S1] = sts[1];
    b[B_SHR_M0 +: NCH] = msk;
    return b;
  endfunction
endpackage

// File: rtl/ide_irq_req_edge.sv
module ide_irq_req_edge
  import ide_irq_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] req,
  output logic [NCH-1:0] rise,
  output logic [NCH-1:0] fall
);
  logic [NCH-1:0] req_q;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    always_ff @(posedge clk) begin
      if (!rst_n) req_q[c] <= 1'b0;
      else        req_q[c] <= req[c];
    end
    assign rise[c] = req[c] & ~req_q[c];
    assign fall[c] = ~req[c] & req_q[c];
  end
endmodule

// File: rtl/ide_irq_cfg_decode.sv
module ide_irq_cfg_decode
  import ide_irq_pkg::*;
(
  input  logic           cfg_we,
  input  logic [5:0]     cfg_waddr,
  input  logic [3:0]     cfg_be,
  input  logic [31:0]    cfg_wdata,
  output logic [NCH-1:0] clr,
  output logic           en_we,
  output logic [7:0]     en_wdata
);
  logic hit_ch0, hit_ch1, hit_shr;
  logic unused_wdata;

  assign hit_ch0 = cfg_we && (cfg_waddr == DW_CH0) && cfg_be[LN_CH0];
  assign hit_ch1 = cfg_we && (cfg_waddr == DW_CH1) && cfg_be[LN_CH1];
  assign hit_shr = cfg_we && (cfg_waddr == DW_SHR) && cfg_be[LN_SHR];

  // one-to-clear through either alias of a channel
  assign clr[0] = (hit_ch0 && cfg_wdata[LN_CH0*8 + B_CH0_STS]) ||
                  (hit_shr && cfg_wdata[LN_SHR*8 + B_SHR_S0]);
  assign clr[1] = (hit_ch1 && cfg_wdata[LN_CH1*8 + B_CH1_STS]) ||
                  (hit_shr && cfg_wdata[LN_SHR*8 + B_SHR_S1]);

  assign en_we    = cfg_we && (cfg_waddr == DW_EN) && cfg_be[LN_EN];
  assign en_wdata = cfg_wdata[LN_EN*8 +: 8];

  assign unused_wdata = ^cfg_wdata;
endmodule

// File: rtl/ide_irq_bm_regs.sv
module ide_irq_bm_regs
  import ide_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bm_we,
  input  logic [CH_W-1:0]  bm_chan,
  input  logic [2:0]       bm_off,
  input  logic [7:0]       bm_wdata,
  input  logic [NCH*3-1:0] dma_set,
  output logic [NCH-1:0]   mask,
  output logic [NCH*8-1:0] bm_status,
  output logic             ctl_wr,
  output logic [NCH-1:0]   sts_wr
);
  assign ctl_wr = bm_we && (bm_off == BM_OFF_CTL);

  always_ff @(posedge clk) begin
    if (!rst_n)      mask <= '0;
    else if (ctl_wr) mask <= bm_wdata[B_SHR_M0 +: NCH];
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [7:0] after_wr;
    assign sts_wr[c] = bm_we && (bm_off == BM_OFF_STS) && (bm_chan == CH_W'(c));
    assign after_wr  = sts_wr[c] ? bm_status_next(bm_status[c*8 +: 8], bm_wdata)
                                 : bm_status[c*8 +: 8];
    always_ff @(posedge clk) begin
      if (!rst_n) bm_status[c*8 +: 8] <= '0;
      else        bm_status[c*8 +: 8] <= after_wr | {5'b0, dma_set[c*3 +: 3]};
    end
  end
endmodule

// File: rtl/ide_irq_status_regs.sv
module ide_irq_status_regs
  import ide_irq_pkg::*;
#(
  parameter bit HAS_SECONDARY = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [5:0]  cfg_waddr,
  input  logic [3:0]  cfg_be,
  input  logic [31:0] cfg_wdata,
  input  logic [5:0]  cfg_raddr,
  output logic [31:0] cfg_rdata,
  input  logic        bm_we,
  input  logic        bm_chan,
  input  logic [2:0]  bm_off,
  input  logic [7:0]  bm_wdata,
  output logic [15:0] bm_status,
  input  logic [5:0]  dma_set,
  input  logic [1:0]  irq_req,
  output logic        irq
);
  localparam logic [7:0] EN_RST = 8'h04 | (HAS_SECONDARY ? 8'h08 : 8'h00);

  logic [NCH-1:0] rise, fall, clr, sts, mask, bm_sts_wr;
  logic           bm_ctl_wr, en_we;
  logic [7:0]     en_wdata, en_q;

  ide_irq_req_edge u_edge (
    .clk(clk), .rst_n(rst_n), .req(irq_req), .rise(rise), .fall(fall)
  );

  ide_irq_cfg_decode u_dec (
    .cfg_we(cfg_we), .cfg_waddr(cfg_waddr), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
    .clr(clr), .en_we(en_we), .en_wdata(en_wdata)
  );

  ide_irq_bm_regs u_bm (
    .clk(clk), .rst_n(rst_n), .bm_we(bm_we), .bm_chan(bm_chan), .bm_off(bm_off),
    .bm_wdata(bm_wdata), .dma_set(dma_set), .mask(mask), .bm_status(bm_status),
    .ctl_wr(bm_ctl_wr), .sts_wr(bm_sts_wr)
  );

  // single flop per channel feeds both aliases; request edge outranks a clear
  for (genvar c = 0; c < NCH; c++) begin : g_sts
    always_ff @(posedge clk) begin
      if (!rst_n)       sts[c] <= 1'b0;
      else if (rise[c]) sts[c] <= 1'b1;
      else if (fall[c]) sts[c] <= 1'b0;
      else if (clr[c])  sts[c] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     en_q <= EN_RST;
    else if (en_we) en_q <= en_wdata;
  end

  always_comb begin
    cfg_rdata = '0;
    if (cfg_raddr == DW_CH0) cfg_rdata[LN_CH0*8 + B_CH0_STS] = sts[0];
    if (cfg_raddr == DW_EN)  cfg_rdata[LN_EN*8 +: 8] = en_q;
    if (cfg_raddr == DW_CH1) cfg_rdata[LN_CH1*8 + B_CH1_STS] = sts[1];
    if (cfg_raddr == DW_SHR) cfg_rdata[LN_SHR*8 +: 8] = shared_byte(sts, mask);
  end

  assign irq = irq_level(sts, mask);
endmodule

// File: rtl/ide_irq_chk.sv
module ide_irq_chk
  import ide_irq_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [NCH-1:0]   rise,
  input logic [NCH-1:0]   fall,
  input logic [NCH-1:0]   clr,
  input logic [NCH-1:0]   sts,
  input logic [NCH-1:0]   mask,
  input logic             irq,
  input logic             bm_ctl_wr,
  input logic [7:0]       bm_wdata,
  input logic [NCH-1:0]   bm_sts_wr,
  input logic [NCH*3-1:0] dma_set,
  input logic [NCH*8-1:0] bm_status
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    a_r3_rise_sets: assert property (@(posedge clk) disable iff (!rst_n)
      rise[c] |=> sts[c]);
    a_r3_fall_clears: assert property (@(posedge clk) disable iff (!rst_n)
      fall[c] |=> !sts[c]);
    a_r4_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[c] && !rise[c]) |=> !sts[c]);
    a_r11_edge_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[c] && rise[c]) |=> sts[c]);
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!rise[c] && !fall[c] && !clr[c]) |=> $stable(sts[c]));
    a_r9_keep_busy: assert property (@(posedge clk) disable iff (!rst_n)
      bm_sts_wr[c] |=> (bm_status[c*8] == ($past(bm_status[c*8]) | $past(dma_set[c*3]))));
  end

  a_r8_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
    bm_ctl_wr |=> (mask == $past(bm_wdata[B_SHR_M0 +: NCH])));
  a_r8_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bm_ctl_wr |=> $stable(mask));
  a_r10_irq_needs_sts: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (sts != '0));
endmodule

bind ide_irq_status_regs ide_irq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rise(rise), .fall(fall), .clr(clr), .sts(sts),
  .mask(mask), .irq(irq), .bm_ctl_wr(bm_ctl_wr), .bm_wdata(bm_wdata),
  .bm_sts_wr(bm_sts_wr), .dma_set(dma_set), .bm_status(bm_status)
);

// File: tb/ide_irq_status_regs_bench.sv
module ide_irq_status_regs_bench;
  localparam time CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [5:0]  cfg_waddr = '0;
  logic [3:0]  cfg_be = '0;
  logic [31:0] cfg_wdata = '0;
  logic [5:0]  cfg_raddr = '0;
  logic [31:0] cfg_rdata;
  logic        bm_we = 1'b0;
  logic        bm_chan = 1'b0;
  logic [2:0]  bm_off = '0;
  logic [7:0]  bm_wdata = '0;
  logic [15:0] bm_status;
  logic [5:0]  dma_set = '0;
  logic [1:0]  irq_req = '0;
  logic        irq;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  ide_irq_status_regs u_ide_irq_status_regs (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_errors++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic rd(input string req, input logic [5:0] dw, input logic [31:0] exp);
    cfg_raddr = dw;
    #1;
    check(req, cfg_rdata, exp);
  endtask

  task automatic cfg_wr(input logic [5:0] dw, input logic [3:0] be, input logic [31:0] d);
    cfg_we = 1'b1; cfg_waddr = dw; cfg_be = be; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic bm_wr(input logic ch, input logic [2:0] off, input logic [7:0] d);
    bm_we = 1'b1; bm_chan = ch; bm_off = off; bm_wdata = d;
    @(negedge clk);
    bm_we = 1'b0;
  endtask

  task automatic set_req(input logic [1:0] v);
    irq_req = v;
    @(negedge clk);
  endtask

  task automatic t_reset;
    rd("R1 R7 reset 0x50-0x53", 6'h14, 32'h0000_0C00);
    rd("R1 reset 0x54-0x57", 6'h15, 32'h0);
    rd("R1 reset 0x70-0x73", 6'h1C, 32'h0);
    check("R1 reset bm_status", {16'h0, bm_status}, 32'h0);
    check("R1 reset irq", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_edges;
    set_req(2'b01);
    rd("R2 R3 ch0 set at 0x50", 6'h14, 32'h0000_0C04);
    rd("R2 R3 ch0 set at 0x71", 6'h1C, 32'h0000_0400);
    check("R10 irq ch0", {31'h0, irq}, 32'h1);
    set_req(2'b11);
    rd("R2 R3 ch1 set at 0x57", 6'h15, 32'h1000_0000);
    rd("R2 R3 both at 0x71", 6'h1C, 32'h0000_0C00);
    set_req(2'b10);
    rd("R3 ch0 fall 0x50", 6'h14, 32'h0000_0C00);
    rd("R3 ch0 fall 0x71", 6'h1C, 32'h0000_0800);
    check("R10 irq ch1 only", {31'h0, irq}, 32'h1);
    set_req(2'b00);
    rd("R3 ch1 fall 0x57", 6'h15, 32'h0);
    check("R10 irq idle", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_w1c;
    set_req(2'b01);
    cfg_wr(6'h14, 4'b0001, 32'h0000_0000);
    rd("R4 zero write keeps ch0", 6'h14, 32'h0000_0C04);
    cfg_wr(6'h14, 4'b0001, 32'h0000_00FB);
    rd("R5 other bits of 0x50", 6'h14, 32'h0000_0C04);
    cfg_wr(6'h14, 4'b0001, 32'h0000_0004);
    rd("R4 clear via 0x50", 6'h14, 32'h0000_0C00);
    rd("R4 clear mirrored 0x71", 6'h1C, 32'h0);
    check("R4 R10 irq after clear", {31'h0, irq}, 32'h0);
    set_req(2'b00); set_req(2'b01);
    cfg_wr(6'h1C, 4'b0010, 32'h0000_0400);
    rd("R4 clear via 0x71 mirrored 0x50", 6'h14, 32'h0000_0C00);
    set_req(2'b11);
    cfg_wr(6'h15, 4'b1000, 32'hEF00_0000);
    rd("R5 other bits of 0x57", 6'h15, 32'h1000_0000);
    cfg_wr(6'h15, 4'b1000, 32'h1000_0000);
    rd("R4 clear via 0x57 mirrored 0x71", 6'h1C, 32'h0);
    set_req(2'b01); set_req(2'b11);
    cfg_wr(6'h1C, 4'b0010, 32'h0000_0800);
    rd("R4 clear via 0x71 mirrored 0x57", 6'h15, 32'h0);
  endtask

  task automatic t_lanes;
    set_req(2'b00); set_req(2'b01);
    cfg_wr(6'h14, 4'b1110, 32'hFFFF_FF04);
    rd("R6 R7 lane0 disabled, enable written", 6'h14, 32'h0000_FF04);
    cfg_wr(6'h14, 4'b0011, 32'h0000_0C04);
    rd("R6 enable and clear in one access", 6'h14, 32'h0000_0C00);
    cfg_wr(6'h1C, 4'b1111, 32'hFFFF_F3FF);
    rd("R5 mask bits ignore cfg writes", 6'h1C, 32'h0);
  endtask

  task automatic t_bm_ctl;
    set_req(2'b00); set_req(2'b01);
    bm_wr(1'b0, 3'd1, 8'hFF);
    rd("R8 both masks set", 6'h1C, 32'h0000_3400);
    check("R10 irq masked", {31'h0, irq}, 32'h0);
    rd("R8 status kept at 0x50", 6'h14, 32'h0000_0C04);
    bm_wr(1'b1, 3'd1, 8'h20);
    rd("R8 ch0 unmasked", 6'h1C, 32'h0000_2400);
    check("R10 irq unmasked ch0", {31'h0, irq}, 32'h1);
    set_req(2'b11);
    bm_wr(1'b0, 3'd1, 8'h10);
    rd("R8 ch1 unmasked", 6'h1C, 32'h0000_1C00);
    check("R10 irq via ch1", {31'h0, irq}, 32'h1);
    bm_wr(1'b0, 3'd1, 8'h30);
    check("R10 irq both masked", {31'h0, irq}, 32'h0);
    bm_wr(1'b1, 3'd1, 8'hCF);
    rd("R8 only bits 5:4 taken", 6'h1C, 32'h0000_0C00);
    bm_wr(1'b0, 3'd0, 8'h30);
    bm_wr(1'b1, 3'd3, 8'h30);
    rd("R8 other offsets no mask effect", 6'h1C, 32'h0000_0C00);
    check("R10 irq after offsets", {31'h0, irq}, 32'h1);
  endtask

  task automatic t_bm_status;
    dma_set = 6'b000_111;
    @(negedge clk);
    dma_set = '0;
    check("R9 set pulses ch0", {16'h0, bm_status}, 32'h0000_0007);
    bm_wr(1'b0, 3'd2, 8'h62);
    check("R9 mixed write ch0", {16'h0, bm_status}, 32'h0000_0065);
    bm_wr(1'b0, 3'd2, 8'h04);
    check("R9 clear bit2 keep bit0", {16'h0, bm_status}, 32'h0000_0001);
    dma_set = 6'b110_000;
    @(negedge clk);
    dma_set = '0;
    check("R9 set pulses ch1", {16'h0, bm_status}, 32'h0000_0601);
    bm_wr(1'b1, 3'd2, 8'hFF);
    check("R9 all-ones write ch1", {16'h0, bm_status}, 32'h0000_6001);
  endtask

  task automatic t_edge_wins;
    set_req(2'b10);
    rd("R3 ch0 fall before race", 6'h14, 32'h0000_0C00);
    irq_req = 2'b11;
    cfg_wr(6'h14, 4'b0001, 32'h0000_0004);
    rd("R11 rise beats clear", 6'h14, 32'h0000_0C04);
  endtask

  task automatic t_reads;
    rd("R12 first read", 6'h1C, 32'h0000_0C00);
    @(negedge clk);
    rd("R12 repeat read", 6'h1C, 32'h0000_0C00);
    rd("R12 alias unchanged", 6'h14, 32'h0000_0C04);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_edges();
    t_w1c();
    t_lanes();
    t_bm_ctl();
    t_bm_status();
    t_edge_wins();
    t_reads();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule